// File: doc/BRIEF.md
# Dual-Core System Control Register Block

This block is a word-addressed register file that sits on a simple memory-mapped bus and controls a two-core subsystem. It keeps a secure debug status word, reset bookkeeping, a general retention word, per-core boot vector addresses, a per-core hold-in-wait mask, clock divider and clock forcing fields, wake-up control words and power-domain sense words. The clock, power and core logic that would use these values lie outside the block. The block only stores the values and drives them out.

A 32-bit version parameter fixes the feature level at elaboration. An extended level adds a set of registers. At the base level those offsets decode as holes. The block turns two kinds of software writes into single-cycle events. The first is a pulse to a core that should power on and restart when its hold bit is cleared. The second is a whole-system reset request.

Access is one request per cycle. A write takes effect at the clock edge that samples it. Read data appears on `bus_rdata` one cycle after the read request and holds until the next read.

Top module: `sysctl_top`

## Requirements
- R1: The extended level is active when bits [31:28] of parameter `VERSION` equal 2. Any other value selects the base level.
- R2: At the base level, the byte offsets 0x00C, 0x010, 0x014, 0x018, 0x114, 0x124, 0x200, 0x20C, 0x210, 0x214, 0x218 and 0x11C read as zero, and writes to them change nothing. In particular, `cpu_vec1` keeps its reset value.
- R3: At the extended level, all offsets listed in R2 are full 32-bit read/write registers. Offset 0x11C is the NMI enable word.
- R4: Offset 0x118 holds the wait mask. Bit n drives `cpu_hold[n]`. A write that takes bit n from 1 to 0 raises `cpu_release[n]` for exactly one cycle, in the cycle after the write, together with the new mask. Writes that leave bit n at 0, leave it at 1, or raise it give no pulse.
- R5: Writes to 0x110 drive `cpu_vec0`, and writes to 0x114 (extended level) drive `cpu_vec1`. Both outputs change in the cycle after the write and read back at the same offsets.
- R6: A write to 0x108 with bit 9 set raises `sys_reset_req` for one cycle, in the cycle after the write. With bit 9 clear there is no request. Offset 0x108 reads zero.
- R7: After reset, the following values hold. 0x100 reads 1. 0x200 reads 0x7F at the extended level. `cpu_vec0` equals `VEC0_RST`, `cpu_vec1` equals `VEC1_RST`, and `cpu_hold` equals `WAIT_RST`. No pulse or request is active. Every other register reads 0.
- R8: A write to 0x004 ORs data into the debug status word. A write to 0x008 clears the bits that are set in the data. Offset 0x000 returns the word, and writes to 0x000 are ignored.
- R9: Offsets 0xFD0 to 0xFFC are a read-only identification table. Word k returns 0x04, 0, 0, 0, 0x56, 0xB8, 0x0B, 0, 0x0D, 0xF0, 0x05, 0xB1 for k = 0 to 11. Writes are ignored.
- R10: Offsets that map to nothing, including unaligned ones, read zero, and writes to them have no effect.
- R11: `bus_rdata` is updated only by a read request, one cycle after it, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read |
| cpu_vec0 | output | 32 | Boot vector for core 0 |
| cpu_vec1 | output | 32 | Boot vector for core 1 |
| cpu_hold | output | 2 | Per-core hold-in-wait mask |
| cpu_release | output | 2 | Per-core power-on-and-restart pulse |
| sys_reset_req | output | 1 | Whole-system reset request pulse |

## Verification
The case that is hardest to reach is a release pulse, because it depends on the stored mask as well as on the write. A write only pulses if the earlier state of the bit was 1. The bench therefore elaborates the core with both hold bits set at reset. It then walks the mask through clear-one, rewrite-same, clear-other, raise-both and clear-both, and checks each pulse and its absence on the sampling cycle. Two instances, one at each level, share the bus, so every write to an extended-only offset is checked against both behaviours at once.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int NCPU      = 2;
    localparam int NSRAM     = 4;
    localparam int SWRST_BIT = 9;
    localparam logic [3:0] EXT_CODE = 4'h2;

    // byte offsets
    localparam logic [ADDR_W-1:0] A_DBG_STAT = 12'h000;
    localparam logic [ADDR_W-1:0] A_DBG_SET  = 12'h004;
    localparam logic [ADDR_W-1:0] A_DBG_CLR  = 12'h008;
    localparam logic [ADDR_W-1:0] A_SEC_CTL  = 12'h00C;
    localparam logic [ADDR_W-1:0] A_FCLK     = 12'h010;
    localparam logic [ADDR_W-1:0] A_SCLK     = 12'h014;
    localparam logic [ADDR_W-1:0] A_CLKF     = 12'h018;
    localparam logic [ADDR_W-1:0] A_SYND     = 12'h100;
    localparam logic [ADDR_W-1:0] A_RMASK    = 12'h104;
    localparam logic [ADDR_W-1:0] A_SWRST    = 12'h108;
    localparam logic [ADDR_W-1:0] A_GRET     = 12'h10C;
    localparam logic [ADDR_W-1:0] A_VEC0     = 12'h110;
    localparam logic [ADDR_W-1:0] A_VEC1     = 12'h114;
    localparam logic [ADDR_W-1:0] A_WAIT     = 12'h118;
    localparam logic [ADDR_W-1:0] A_NMI      = 12'h11C;
    localparam logic [ADDR_W-1:0] A_WIC      = 12'h120;
    localparam logic [ADDR_W-1:0] A_EW       = 12'h124;
    localparam logic [ADDR_W-1:0] A_PDSYS    = 12'h200;
    localparam logic [ADDR_W-1:0] A_SRAM0    = 12'h20C;
    localparam logic [ADDR_W-1:0] A_ID_BASE  = 12'hFD0;

    typedef enum logic [4:0] {
        S_DBG, S_SEC, S_FCLK, S_SCLK, S_CLKF, S_SYND, S_RMASK, S_GRET,
        S_VEC0, S_VEC1, S_WAIT, S_NMI, S_WIC, S_EW, S_PDSYS,
        S_SRAM0, S_SRAM1, S_SRAM2, S_SRAM3
    } slot_e;
    localparam int NSLOT = 19;

    typedef enum logic [1:0] {W_NONE, W_LOAD, W_SET, W_CLR} wmode_e;
    typedef enum logic [1:0] {RD_ZERO, RD_SLOT, RD_ID} rsrc_e;

    typedef struct packed {
        slot_e      slot;
        wmode_e     wmode;
        rsrc_e      rsrc;
        logic [3:0] id_idx;
        logic       swrst;
    } dec_t;

    function automatic logic is_ext(input logic [31:0] ver);
        return ver[31:28] == EXT_CODE;
    endfunction

    function automatic logic [DATA_W-1:0] id_word(input logic [3:0] k);
        logic [7:0] b;
        case (k)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h56;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h0B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return {{(DATA_W-8){1'b0}}, b};
    endfunction

    function automatic logic [DATA_W-1:0] slot_reset(
        input slot_e s, input logic [DATA_W-1:0] v0,
        input logic [DATA_W-1:0] v1, input logic [DATA_W-1:0] w);
        case (s)
            S_SYND:  return 32'h1;
            S_PDSYS: return 32'h7F;
            S_VEC0:  return v0;
            S_VEC1:  return v1;
            S_WAIT:  return w;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter bit EXT = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec = '{slot: S_DBG, wmode: W_NONE, rsrc: RD_ZERO, id_idx: 4'd0, swrst: 1'b0};
        case (addr)
            A_DBG_STAT: dec.rsrc = RD_SLOT;
            A_DBG_SET:  dec.wmode = W_SET;
            A_DBG_CLR:  dec.wmode = W_CLR;
            A_SYND:     begin dec.slot = S_SYND;  dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_RMASK:    begin dec.slot = S_RMASK; dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_SWRST:    dec.swrst = 1'b1;
            A_GRET:     begin dec.slot = S_GRET;  dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_VEC0:     begin dec.slot = S_VEC0;  dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_WAIT:     begin dec.slot = S_WAIT;  dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_WIC:      begin dec.slot = S_WIC;   dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_SEC_CTL:  if (EXT) begin dec.slot = S_SEC;   dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_FCLK:     if (EXT) begin dec.slot = S_FCLK;  dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_SCLK:     if (EXT) begin dec.slot = S_SCLK;  dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_CLKF:     if (EXT) begin dec.slot = S_CLKF;  dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_VEC1:     if (EXT) begin dec.slot = S_VEC1;  dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_NMI:      if (EXT) begin dec.slot = S_NMI;   dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_EW:       if (EXT) begin dec.slot = S_EW;    dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            A_PDSYS:    if (EXT) begin dec.slot = S_PDSYS; dec.wmode = W_LOAD; dec.rsrc = RD_SLOT; end
            default: begin
                if (EXT && addr >= A_SRAM0 && addr <= A_SRAM0 + 12'(4*(NSRAM-1))
                    && addr[1:0] == 2'b00) begin
                    dec.slot  = slot_e'(S_SRAM0 + 5'((addr - A_SRAM0) >> 2));
                    dec.wmode = W_LOAD;
                    dec.rsrc  = RD_SLOT;
                end else if (addr >= A_ID_BASE && addr[1:0] == 2'b00) begin
                    dec.rsrc   = RD_ID;
                    dec.id_idx = 4'((addr - A_ID_BASE) >> 2);
                end
            end
        endcase
    end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] VEC0_RST = 32'h1000_0000,
    parameter logic [DATA_W-1:0] VEC1_RST = 32'h1000_0000,
    parameter logic [NCPU-1:0]   WAIT_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] slot_q [NSLOT]
);
    localparam logic [DATA_W-1:0] WAIT_RST_W = DATA_W'(WAIT_RST);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam slot_e SID = slot_e'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= slot_reset(SID, VEC0_RST, VEC1_RST, WAIT_RST_W);
            end else if (we && dec.slot == SID) begin
                case (dec.wmode)
                    W_LOAD:  slot_q[g] <= wdata;
                    W_SET:   slot_q[g] <= slot_q[g] | wdata;
                    W_CLR:   slot_q[g] <= slot_q[g] & ~wdata;
                    default: slot_q[g] <= slot_q[g];
                endcase
            end
        end
    end
endmodule

// File: rtl/sysctl_events.sv
module sysctl_events
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_go,
    input  logic            hit_wait,
    input  logic            hit_swrst,
    input  logic [NCPU-1:0] wdata_lo,
    input  logic            wdata_sw,
    input  logic [NCPU-1:0] hold,
    output logic [NCPU-1:0] release_o,
    output logic            reset_req_o
);
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (rst) release_o[c] <= 1'b0;
            else     release_o[c] <= wr_go && hit_wait && hold[c] && !wdata_lo[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) reset_req_o <= 1'b0;
        else     reset_req_o <= wr_go && hit_swrst && wdata_sw;
    end
endmodule

// File: rtl/sysctl_top.sv
module sysctl_top
    import sysctl_pkg::*;
#(
    parameter logic [31:0]       VERSION  = 32'h2000_0000,
    parameter logic [DATA_W-1:0] VEC0_RST = 32'h1000_0000,
    parameter logic [DATA_W-1:0] VEC1_RST = 32'h1000_0000,
    parameter logic [NCPU-1:0]   WAIT_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] cpu_vec0,
    output logic [DATA_W-1:0] cpu_vec1,
    output logic [NCPU-1:0]   cpu_hold,
    output logic [NCPU-1:0]   cpu_release,
    output logic              sys_reset_req
);
    localparam bit EXT = is_ext(VERSION);

    dec_t              dec;
    logic              wr_go;
    logic [DATA_W-1:0] slot_q [NSLOT];

    assign wr_go = bus_sel && bus_wr;

    sysctl_decode #(.EXT(EXT)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    sysctl_regfile #(
        .VEC0_RST (VEC0_RST),
        .VEC1_RST (VEC1_RST),
        .WAIT_RST (WAIT_RST)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_go),
        .dec    (dec),
        .wdata  (bus_wdata),
        .slot_q (slot_q)
    );

    assign cpu_vec0 = slot_q[S_VEC0];
    assign cpu_vec1 = slot_q[S_VEC1];
    assign cpu_hold = slot_q[S_WAIT][NCPU-1:0];

    sysctl_events u_evt (
        .clk         (clk),
        .rst         (rst),
        .wr_go       (wr_go),
        .hit_wait    (dec.wmode == W_LOAD && dec.slot == S_WAIT),
        .hit_swrst   (dec.swrst),
        .wdata_lo    (bus_wdata[NCPU-1:0]),
        .wdata_sw    (bus_wdata[SWRST_BIT]),
        .hold        (cpu_hold),
        .release_o   (cpu_release),
        .reset_req_o (sys_reset_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_sel && !bus_wr) begin
            case (dec.rsrc)
                RD_SLOT: bus_rdata <= slot_q[dec.slot];
                RD_ID:   bus_rdata <= id_word(dec.id_idx);
                default: bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk
    import sysctl_pkg::*;
#(
    parameter logic [31:0] VERSION = 32'h2000_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] cpu_vec0,
    input logic [DATA_W-1:0] cpu_vec1,
    input logic [NCPU-1:0]   cpu_hold,
    input logic [NCPU-1:0]   cpu_release,
    input logic              sys_reset_req
);
    logic w_wait, w_swrst, w_vec0, w_vec1, rd_req;
    assign w_wait  = bus_sel && bus_wr && bus_addr == 12'h118;
    assign w_swrst = bus_sel && bus_wr && bus_addr == 12'h108;
    assign w_vec0  = bus_sel && bus_wr && bus_addr == 12'h110;
    assign w_vec1  = bus_sel && bus_wr && bus_addr == 12'h114;
    assign rd_req  = bus_sel && !bus_wr;

    for (genvar c = 0; c < NCPU; c++) begin : g_c
        // R4: a release pulse follows a 1->0 write of that hold bit
        p_release_cause_r4: assert property (@(posedge clk) disable iff (rst)
            cpu_release[c] |-> ($past(w_wait) && !$past(bus_wdata[c]) && $past(cpu_hold[c])));
    end

    // R4: the hold mask moves only after a write to its offset
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(w_wait) |-> $stable(cpu_hold));

    // R6: a reset request follows a bit-9 write to the reset offset
    p_sysreq_cause_r6: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |-> ($past(w_swrst) && $past(bus_wdata[SWRST_BIT])));

    // R5: core 0 vector changes only after a write to its offset
    p_vec0_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(w_vec0) |-> $stable(cpu_vec0));

    // R11: read data holds when no read was requested
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_req) |-> $stable(bus_rdata));

    if (!is_ext(VERSION)) begin : g_base
        // R2: base level never moves core 1 vector
        p_base_vec1_r2: assert property (@(posedge clk) disable iff (rst)
            $stable(cpu_vec1));
    end else begin : g_ext
        // R5: core 1 vector changes only after a write to its offset
        p_vec1_stable_r5: assert property (@(posedge clk) disable iff (rst)
            !$past(w_vec1) |-> $stable(cpu_vec1));
    end
endmodule

bind sysctl_top sysctl_chk #(.VERSION(VERSION)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .cpu_vec0      (cpu_vec0),
    .cpu_vec1      (cpu_vec1),
    .cpu_hold      (cpu_hold),
    .cpu_release   (cpu_release),
    .sys_reset_req (sys_reset_req)
);

// File: tb/tb_sysctl_top.sv
module tb_sysctl_top;
    localparam int T = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;

    logic [31:0] rd_e, rd_b, v0_e, v0_b, v1_e, v1_b;
    logic [1:0]  hold_e, hold_b, rel_e, rel_b;
    logic        srq_e, srq_b;

    int total = 0;
    int bad = 0;

    always #(T/2) clk = ~clk;

    sysctl_top #(.VERSION(32'h2000_0000), .WAIT_RST(2'b11)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_e),
        .cpu_vec0(v0_e), .cpu_vec1(v1_e), .cpu_hold(hold_e),
        .cpu_release(rel_e), .sys_reset_req(srq_e));

    sysctl_top #(.VERSION(32'h1000_0000), .VEC1_RST(32'h0000_4000),
                 .WAIT_RST(2'b11)) dut_base (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b),
        .cpu_vec0(v0_b), .cpu_vec1(v1_b), .cpu_hold(hold_b),
        .cpu_release(rel_b), .sys_reset_req(srq_b));

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%h exp=%h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        chk("R7", "vec0 ext", v0_e, 32'h1000_0000);
        chk("R7", "vec0 base", v0_b, 32'h1000_0000);
        chk("R7", "vec1 ext", v1_e, 32'h1000_0000);
        chk("R7", "vec1 base", v1_b, 32'h0000_4000);
        chk("R7", "hold", {30'd0, hold_e, hold_b}, 32'hF);
        chk("R7", "pulses", {28'd0, rel_e, rel_b}, 32'h0);
        chk("R7", "sysreq", {30'd0, srq_e, srq_b}, 32'h0);
        rd(12'h100);
        chk("R7", "syndrome ext", rd_e, 32'h1);
        chk("R7", "syndrome base", rd_b, 32'h1);
        rd(12'h200);
        chk("R7", "pd sys ext", rd_e, 32'h7F);
        chk("R2", "pd sys base", rd_b, 32'h0);
        rd(12'h10C);
        chk("R7", "gret ext", rd_e, 32'h0);
    endtask

    task automatic t_variant();
        logic [11:0] ext_list [12] = '{12'h00C, 12'h010, 12'h014, 12'h018,
            12'h114, 12'h124, 12'h200, 12'h20C, 12'h210, 12'h214, 12'h218, 12'h11C};
        for (int i = 0; i < 12; i++) wr(ext_list[i], 32'hA5A5_0000 + 32'(i));
        for (int i = 0; i < 12; i++) begin
            rd(ext_list[i]);
            chk("R1 R3", "ext reg readback", rd_e, 32'hA5A5_0000 + 32'(i));
            chk("R1 R2", "base hole reads zero", rd_b, 32'h0);
        end
        chk("R5", "vec1 ext after write", v1_e, 32'hA5A5_0004);
        chk("R2", "vec1 base unchanged", v1_b, 32'h0000_4000);
    endtask

    task automatic t_vec();
        wr(12'h110, 32'h0002_0400);
        chk("R5", "vec0 ext", v0_e, 32'h0002_0400);
        chk("R5", "vec0 base", v0_b, 32'h0002_0400);
        wr(12'h114, 32'hDEAD_0000);
        chk("R5", "vec1 ext", v1_e, 32'hDEAD_0000);
        chk("R2", "vec1 base", v1_b, 32'h0000_4000);
        rd(12'h110);
        chk("R5", "vec0 readback", rd_e, 32'h0002_0400);
    endtask

    task automatic t_wait();
        wr(12'h118, 32'h2);
        chk("R4", "clear bit0 pulse ext", {30'd0, rel_e}, 32'h1);
        chk("R4", "clear bit0 pulse base", {30'd0, rel_b}, 32'h1);
        chk("R4", "hold after", {30'd0, hold_e}, 32'h2);
        @(negedge clk);
        chk("R4", "pulse one cycle", {30'd0, rel_e}, 32'h0);
        wr(12'h118, 32'h2);
        chk("R4", "rewrite same no pulse", {30'd0, rel_e}, 32'h0);
        wr(12'h118, 32'h0);
        chk("R4", "clear bit1 pulse", {30'd0, rel_e}, 32'h2);
        wr(12'h118, 32'h3);
        chk("R4", "raise no pulse", {30'd0, rel_e}, 32'h0);
        chk("R4", "hold raised", {30'd0, hold_b}, 32'h3);
        wr(12'h118, 32'h0);
        chk("R4", "clear both", {28'd0, rel_e, rel_b}, 32'hF);
        rd(12'h118);
        chk("R4", "wait readback", rd_e, 32'h0);
    endtask

    task automatic t_swrst();
        wr(12'h108, 32'h0000_0200);
        chk("R6", "request", {30'd0, srq_e, srq_b}, 32'h3);
        @(negedge clk);
        chk("R6", "request one cycle", {30'd0, srq_e, srq_b}, 32'h0);
        wr(12'h108, 32'hFFFF_FDFF);
        chk("R6", "bit9 clear no request", {31'd0, srq_e}, 32'h0);
        rd(12'h108);
        chk("R6", "reads zero", rd_e, 32'h0);
    endtask

    task automatic t_dbg();
        wr(12'h004, 32'h0000_00F0);
        rd(12'h000);
        chk("R8", "set bits", rd_e, 32'hF0);
        wr(12'h008, 32'h0000_0030);
        rd(12'h000);
        chk("R8", "clear bits", rd_b, 32'hC0);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000);
        chk("R8", "status write ignored", rd_e, 32'hC0);
    endtask

    task automatic t_id();
        logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
                                    8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int k = 0; k < 12; k++) begin
            rd(12'hFD0 + 12'(4*k));
            chk("R9", "id word", rd_e, {24'd0, exp_id[k]});
        end
        wr(12'hFE0, 32'h77);
        rd(12'hFE0);
        chk("R9", "id write ignored", rd_b, 32'h56);
    endtask

    task automatic t_undef();
        wr(12'h300, 32'h1234_5678);
        rd(12'h300);
        chk("R10", "hole ext", rd_e, 32'h0);
        chk("R10", "hole base", rd_b, 32'h0);
        wr(12'h102, 32'h5555_5555);
        rd(12'h100);
        chk("R10", "unaligned write no effect", rd_e, 32'h1);
        rd(12'h102);
        chk("R10", "unaligned reads zero", rd_e, 32'h0);
    endtask

    task automatic t_rdlat();
        wr(12'h104, 32'h0000_0005);
        rd(12'h104);
        chk("R11", "read value", rd_e, 32'h5);
        wr(12'h104, 32'h0000_0009);
        @(negedge clk);
        chk("R11", "rdata held without read", rd_e, 32'h5);
        rd(12'h104);
        chk("R11", "new read", rd_e, 32'h9);
    endtask

    initial begin
        #(T * 100000);
        bad++; total++;
        $display("FAIL watchdog: got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_variant();
        t_vec();
        t_wait();
        t_swrst();
        t_dbg();
        t_id();
        t_undef();
        t_rdlat();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule